// File: doc/BRIEF.md
# Banked Framebuffer Window Translator

This block sits between a CPU-side byte bus and an external byte-wide video memory. Each CPU access is mapped to a linear memory offset in one of two ways. Addresses at or above a programmable linear base are linear accesses. Addresses below the base and below the top of the legacy window are banked accesses, placed through a software-selected bank. Addresses in the hole between the window top and the linear base never reach memory. Translation is combinational, so the memory request goes out in the same cycle as the CPU access. Read data returns one cycle later.

Software reaches a small register set through an index port and a data port that share one 16-bit write bus. The set holds an interface identifier, a colour depth, a display control word and the bank number. The control word selects a 32 KB or 64 KB bank size and decides whether enabling the display asks the memory controller to clear all of video memory. Bank writes are checked against the installed memory. A rejected write leaves the bank as it was and raises a one-cycle error pulse. The block also drives a planar offset for the planar pixel path.

Top module: `fbwin_xlate`

## Requirements
- R1: A CPU access with `cpu_addr >= lfb_base` uses offset `cpu_addr - lfb_base`.
- R2: A CPU access below `lfb_base` and below 0xB0000 uses offset `bank * gran_bytes + cpu_addr[15:0]`, where gran_bytes is 32768 or 65536.
- R3: A CPU access below `lfb_base` and at or above 0xB0000 issues no memory request and no write strobe. A read of it returns 0.
- R4: A translated offset at or beyond MEM_KB*1024 issues no memory request and no write strobe. A read of it returns 0.
- R5: Bit 4 of the control word (index 2) selects 32 KB granularity when set and 64 KB when clear. The reset value is 64 KB. A control write that changes the granularity sets both the bank and `plane_off` to 0.
- R6: A bank write (index 3) first keeps only the low 9 data bits. The value is accepted only if it is below MEM_KB/gran_kb, a limit divided by 4 when the depth register (index 1) holds 4. Otherwise the bank is unchanged and `bank_err` is high for exactly one cycle.
- R7: After an accepted bank write, `plane_off` equals the bank shifted left by 16 at 64 KB granularity, or by 15 at 32 KB granularity.
- R8: A write to the identifier register (index 0) is stored only if the value is in 0xB0C0..0xB0C6. The reset value is 0xB0C0.
- R9: A control write that sets bit 0 while bit 0 was clear pulses `clr_req` for one cycle, unless bit 7 of the written value is set. Other control writes do not pulse it.
- R10: A CPU read raises `cpu_rvalid` on the following cycle, with `cpu_rdata` carrying the memory byte for a mapped access.
- R11: `reg_idx_we` loads the index from `reg_wdata`. `reg_dat_we` writes the register the index selects. `reg_rdata` shows that register one cycle after the index settles: index 0 identifier, 1 depth (reset 8), 2 control word (reset 0), 3 bank (reset 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU write when high |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read |
| cpu_rdata | output | 8 | Read data, 0 for unmapped reads |
| lfb_base | input | 32 | Linear framebuffer base address |
| reg_idx_we | input | 1 | Load register index |
| reg_dat_we | input | 1 | Write indexed register |
| reg_wdata | input | 16 | Register write bus |
| reg_rdata | output | 16 | Indexed register value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 18 | Memory byte offset |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after request |
| disp_en | output | 1 | Display enabled (control bit 0) |
| clr_req | output | 1 | Whole-memory clear request pulse |
| bank_err | output | 1 | Rejected bank write pulse |
| plane_off | output | 25 | Planar byte offset of the current bank |

## Verification
The overlap that matters is a banked CPU access in the same cycle as a data-port write to the bank register. The bench points the index at the bank register and programs bank 1. It then raises `cpu_req` to 0xA0010 and `reg_dat_we` carrying bank 2 together. The memory offset seen in that cycle must be 0x10010, from the old bank, and the next access must land at 0x20010. The same check is made with a granularity change racing an access, where the access uses the old bank and size.

// File: rtl/fbwin_pkg.sv
package fbwin_pkg;
  typedef enum logic [1:0] {
    IDX_ID   = 2'd0,
    IDX_BPP  = 2'd1,
    IDX_CTRL = 2'd2,
    IDX_BANK = 2'd3
  } reg_idx_e;

  localparam logic [15:0] ID_FIRST = 16'hB0C0;
  localparam logic [15:0] ID_LAST  = 16'hB0C6;
  localparam int CTRL_ON     = 0;
  localparam int CTRL_GRAN32 = 4;
  localparam int CTRL_KEEP   = 7;
  localparam logic [7:0] BPP_PLANAR = 8'd4;
  localparam logic [7:0] BPP_RESET  = 8'd8;
endpackage

// File: rtl/fbwin_regs.sv
module fbwin_regs
  import fbwin_pkg::*;
#(
  parameter int MEM_KB  = 256,
  parameter int BANK_W  = 9,
  parameter int PLANE_W = BANK_W + 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idx_we,
  input  logic               dat_we,
  input  logic [15:0]        wdata,
  output logic [15:0]        rdata,
  output logic [BANK_W-1:0]  bank,
  output logic               gran32,
  output logic               disp_en,
  output logic [PLANE_W-1:0] plane_off,
  output logic               bank_err,
  output logic               clr_req
);
  localparam logic [15:0] LIM64 = 16'(MEM_KB / 64);
  localparam logic [15:0] LIM32 = 16'(MEM_KB / 32);

  logic [15:0] idx_q;
  logic [15:0] id_q;
  logic [7:0]  bpp_q;
  logic [7:0]  ctrl_q;
  logic [15:0] lim;
  logic [15:0] req_bank;
  logic [15:0] rd_mux;

  assign gran32  = ctrl_q[CTRL_GRAN32];
  assign disp_en = ctrl_q[CTRL_ON];
  assign req_bank = 16'(wdata[BANK_W-1:0]);

  always_comb begin
    lim = gran32 ? LIM32 : LIM64;
    if (bpp_q == BPP_PLANAR) lim = lim >> 2;
  end

  always_comb begin
    rd_mux = 16'd0;
    if (idx_q[15:2] == 14'd0) begin
      case (reg_idx_e'(idx_q[1:0]))
        IDX_ID:   rd_mux = id_q;
        IDX_BPP:  rd_mux = {8'd0, bpp_q};
        IDX_CTRL: rd_mux = {8'd0, ctrl_q};
        IDX_BANK: rd_mux = 16'(bank);
        default:  rd_mux = 16'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= 16'd0;
      id_q      <= ID_FIRST;
      bpp_q     <= BPP_RESET;
      ctrl_q    <= 8'd0;
      bank      <= '0;
      plane_off <= '0;
      bank_err  <= 1'b0;
      clr_req   <= 1'b0;
      rdata     <= 16'd0;
    end else begin
      bank_err <= 1'b0;
      clr_req  <= 1'b0;
      rdata    <= rd_mux;
      if (idx_we) begin
        idx_q <= wdata;
      end else if (dat_we && idx_q[15:2] == 14'd0) begin
        case (reg_idx_e'(idx_q[1:0]))
          IDX_ID: begin
            if (wdata >= ID_FIRST && wdata <= ID_LAST) id_q <= wdata;
          end
          IDX_BPP: bpp_q <= wdata[7:0];
          IDX_CTRL: begin
            ctrl_q <= wdata[7:0];
            if (wdata[CTRL_ON] && !ctrl_q[CTRL_ON] && !wdata[CTRL_KEEP])
              clr_req <= 1'b1;
            if (wdata[CTRL_GRAN32] != ctrl_q[CTRL_GRAN32]) begin
              bank      <= '0;
              plane_off <= '0;
            end
          end
          IDX_BANK: begin
            if (req_bank < lim) begin
              bank      <= wdata[BANK_W-1:0];
              plane_off <= gran32 ? (PLANE_W'(wdata[BANK_W-1:0]) << 15)
                                  : (PLANE_W'(wdata[BANK_W-1:0]) << 16);
            end else begin
              bank_err <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fbwin_map.sv
module fbwin_map #(
  parameter int ADDR_W  = 32,
  parameter int BANK_W  = 9,
  parameter int MA_W    = 18,
  parameter int MEM_KB  = 256,
  parameter logic [ADDR_W-1:0] WIN_END = 32'h000B_0000
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [ADDR_W-1:0] lfb_base,
  input  logic [BANK_W-1:0] bank,
  input  logic              gran32,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam logic [ADDR_W-1:0] MEM_BYTES = ADDR_W'(MEM_KB * 1024);

  logic              is_lfb;
  logic              is_win;
  logic [ADDR_W-1:0] lfb_off;
  logic [ADDR_W-1:0] win_off;
  logic [ADDR_W-1:0] off;
  logic              in_mem;

  always_comb begin
    is_lfb  = cpu_addr >= lfb_base;
    is_win  = !is_lfb && (cpu_addr < WIN_END);
    lfb_off = cpu_addr - lfb_base;
    win_off = (ADDR_W'(bank) << (gran32 ? 15 : 16)) + ADDR_W'(cpu_addr[15:0]);
    off     = is_lfb ? lfb_off : win_off;
    in_mem  = (is_lfb || is_win) && (off < MEM_BYTES);
  end

  assign mem_req   = cpu_req && in_mem;
  assign mem_we    = mem_req && cpu_we;
  assign mem_addr  = off[MA_W-1:0];
  assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/fbwin_rdret.sv
module fbwin_rdret (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_req,
  input  logic       rd_hit,
  input  logic [7:0] mem_rdata,
  output logic       cpu_rvalid,
  output logic [7:0] cpu_rdata
);
  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      cpu_rvalid <= rd_req;
      hit_q      <= rd_req && rd_hit;
    end
  end

  assign cpu_rdata = hit_q ? mem_rdata : 8'd0;
endmodule

// File: rtl/fbwin_xlate.sv
module fbwin_xlate #(
  parameter int ADDR_W = 32,
  parameter int MEM_KB = 256,
  parameter int BANK_W = 9,
  parameter logic [ADDR_W-1:0] WIN_END = 32'h000B_0000,
  localparam int MA_W    = $clog2(MEM_KB * 1024),
  localparam int PLANE_W = BANK_W + 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic               cpu_rvalid,
  output logic [7:0]         cpu_rdata,
  input  logic [ADDR_W-1:0]  lfb_base,
  input  logic               reg_idx_we,
  input  logic               reg_dat_we,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MA_W-1:0]    mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               disp_en,
  output logic               clr_req,
  output logic               bank_err,
  output logic [PLANE_W-1:0] plane_off
);
  logic [BANK_W-1:0] bank_w;
  logic              gran32_w;

  fbwin_regs #(.MEM_KB(MEM_KB), .BANK_W(BANK_W), .PLANE_W(PLANE_W)) u_regs (
    .clk(clk), .rst(rst), .idx_we(reg_idx_we), .dat_we(reg_dat_we),
    .wdata(reg_wdata), .rdata(reg_rdata), .bank(bank_w), .gran32(gran32_w),
    .disp_en(disp_en), .plane_off(plane_off), .bank_err(bank_err),
    .clr_req(clr_req)
  );

  fbwin_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .MA_W(MA_W), .MEM_KB(MEM_KB),
              .WIN_END(WIN_END)) u_map (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .lfb_base(lfb_base), .bank(bank_w),
    .gran32(gran32_w), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  fbwin_rdret u_rdret (
    .clk(clk), .rst(rst), .rd_req(cpu_req && !cpu_we), .rd_hit(mem_req),
    .mem_rdata(mem_rdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
  );
endmodule

// File: rtl/fbwin_chk.sv
module fbwin_chk #(
  parameter int ADDR_W = 32,
  parameter int MEM_KB = 256,
  parameter int BANK_W = 9,
  parameter int PLANE_W = BANK_W + 16,
  parameter logic [ADDR_W-1:0] WIN_END = 32'h000B_0000
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_req,
  input logic               cpu_we,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic [ADDR_W-1:0]  lfb_base,
  input logic               cpu_rvalid,
  input logic               mem_req,
  input logic               mem_we,
  input logic               disp_en,
  input logic               clr_req,
  input logic               bank_err,
  input logic [PLANE_W-1:0] plane_off,
  input logic [BANK_W-1:0]  bank_w,
  input logic               gran32_w
);
  localparam logic [ADDR_W-1:0] MEM_BYTES = ADDR_W'(MEM_KB * 1024);

  a_r3_hole_silent: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_addr < lfb_base && cpu_addr >= WIN_END |-> !mem_req && !mem_we);

  a_r4_lfb_beyond_mem: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_addr >= lfb_base && (cpu_addr - lfb_base) >= MEM_BYTES |-> !mem_we);

  a_r5_gran_zeroes_bank: assert property (@(posedge clk) disable iff (rst)
    !$stable(gran32_w) |-> bank_w == '0 && plane_off == '0);

  a_r6_reject_holds_bank: assert property (@(posedge clk) disable iff (rst)
    bank_err |-> $stable(bank_w));

  a_r7_plane_aligned: assert property (@(posedge clk) disable iff (rst)
    plane_off[14:0] == 15'd0);

  a_r9_clear_once: assert property (@(posedge clk) disable iff (rst)
    clr_req |-> disp_en ##1 !clr_req);

  a_r10_read_returns: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_we |=> cpu_rvalid);
endmodule

bind fbwin_xlate fbwin_chk #(.ADDR_W(ADDR_W), .MEM_KB(MEM_KB), .BANK_W(BANK_W),
                             .PLANE_W(PLANE_W), .WIN_END(WIN_END)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .lfb_base(lfb_base), .cpu_rvalid(cpu_rvalid), .mem_req(mem_req),
  .mem_we(mem_we), .disp_en(disp_en), .clr_req(clr_req), .bank_err(bank_err),
  .plane_off(plane_off), .bank_w(bank_w), .gran32_w(gran32_w)
);

// File: tb/fbwin_xlate_bench.sv
`timescale 1ns/1ps
module fbwin_xlate_bench;
  localparam int MEMKB = 256;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int MEMB = MEMKB * 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic        cpu_rvalid;
  logic [7:0]  cpu_rdata;
  logic        reg_idx_we = 0, reg_dat_we = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [17:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 0;
  logic        disp_en, clr_req, bank_err;
  logic [24:0] plane_off;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  fbwin_xlate #(.MEM_KB(MEMKB)) u_fbwin_xlate (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid),
    .cpu_rdata(cpu_rdata), .lfb_base(BASE), .reg_idx_we(reg_idx_we),
    .reg_dat_we(reg_dat_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .disp_en(disp_en),
    .clr_req(clr_req), .bank_err(bank_err), .plane_off(plane_off)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a ^ (a >> 8) ^ (a >> 16) ^ 32'h5A);
  endfunction

  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= pat(32'(mem_addr));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] idx, input logic [15:0] val);
    @(negedge clk); reg_idx_we = 1; reg_wdata = idx;
    @(negedge clk); reg_idx_we = 0; reg_dat_we = 1; reg_wdata = val;
    @(negedge clk); reg_dat_we = 0;
  endtask

  task automatic reg_rd(input logic [15:0] idx, output logic [15:0] val);
    @(negedge clk); reg_idx_we = 1; reg_wdata = idx;
    @(negedge clk); reg_idx_we = 0;
    @(negedge clk); val = reg_rdata;
  endtask

  task automatic acc(input string r, input logic we, input logic [31:0] a,
                     input logic hit, input logic [31:0] off);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = 8'hC3;
    #1;
    chk({r, " req"}, 32'(mem_req), 32'(hit));
    chk({r, " we"}, 32'(mem_we), 32'(hit && we));
    if (hit) chk({r, " off"}, 32'(mem_addr), off);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    if (!we) begin
      chk({r, " rvalid R10"}, 32'(cpu_rvalid), 32'd1);
      chk({r, " rdata R10"}, 32'(cpu_rdata), hit ? 32'(pat(off)) : 32'd0);
    end
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cur_bank;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R5 R8 R11)
    chk("R11 rvalid reset", 32'(cpu_rvalid), 0);
    chk("R9 clr reset", 32'(clr_req), 0);
    reg_rd(16'd0, v); chk("R8 id reset", 32'(v), 32'hB0C0);
    reg_rd(16'd1, v); chk("R11 bpp reset", 32'(v), 8);
    reg_rd(16'd2, v); chk("R5 ctrl reset", 32'(v), 0);
    reg_rd(16'd3, v); chk("R11 bank reset", 32'(v), 0);
    chk("R7 plane reset", 32'(plane_off), 0);

    // identifier acceptance R8
    reg_wr(16'd0, 16'hB0C3); reg_rd(16'd0, v); chk("R8 id B0C3", 32'(v), 32'hB0C3);
    reg_wr(16'd0, 16'hB0C7); reg_rd(16'd0, v); chk("R8 id B0C7 ignored", 32'(v), 32'hB0C3);
    reg_wr(16'd0, 16'hB0BF); reg_rd(16'd0, v); chk("R8 id B0BF ignored", 32'(v), 32'hB0C3);
    reg_wr(16'd0, 16'hB0C6); reg_rd(16'd0, v); chk("R8 id B0C6", 32'(v), 32'hB0C6);

    // clear request R9
    reg_wr(16'd2, 16'h0081); chk("R9 keep bit suppresses clear", 32'(clr_req), 0);
    reg_wr(16'd2, 16'h0000); chk("R9 disable no clear", 32'(clr_req), 0);
    reg_wr(16'd2, 16'h0001); chk("R9 enable pulses clear", 32'(clr_req), 1);
    chk("R9 disp_en", 32'(disp_en), 1);
    @(negedge clk); chk("R9 clear one cycle", 32'(clr_req), 0);
    reg_wr(16'd2, 16'h0001); chk("R9 re-enable no clear", 32'(clr_req), 0);

    // bank sweep over granularity and depth R2 R5 R6 R7
    cur_bank = 0;
    for (int g = 0; g < 2; g++) begin
      for (int b = 0; b < 2; b++) begin
        int gk, lim;
        gk = g ? 32 : 64;
        lim = MEMKB / gk;
        if (b) lim = lim / 4;
        reg_wr(16'd1, b ? 16'd4 : 16'd8);
        reg_wr(16'd2, g ? 16'h0011 : 16'h0001);
        if (g == 1 && b == 0) cur_bank = 0;
        for (int n = 0; n < 12; n++) begin
          int wv;
          wv = (n == 11) ? 16'h0201 : n;
          reg_wr(16'd3, 16'(wv));
          wv = wv & 16'h1FF;
          chk("R6 bank_err", 32'(bank_err), 32'(wv >= lim));
          if (wv < lim) cur_bank = wv;
          reg_rd(16'd3, v);
          chk("R6 bank readback", 32'(v), 32'(cur_bank));
          chk("R7 plane_off", 32'(plane_off), 32'(cur_bank * gk * 1024));
          if (wv < lim) begin
            acc("R2 window lo", 0, 32'h000A_0000, 1, 32'(cur_bank * gk * 1024));
            acc("R2 window hi", 1, 32'h000A_FFFF,
                (cur_bank * gk * 1024 + 32'hFFFF) < MEMB,
                32'(cur_bank * gk * 1024 + 32'hFFFF));
            acc("R2 window mid", 0, 32'h000A_8123,
                (cur_bank * gk * 1024 + 32'h8123) < MEMB,
                32'(cur_bank * gk * 1024 + 32'h8123));
          end
        end
      end
    end

    // granularity change zeroes bank R5
    reg_wr(16'd1, 16'd8);
    reg_wr(16'd2, 16'h0001);
    reg_wr(16'd3, 16'd2);
    reg_wr(16'd2, 16'h0001);
    reg_rd(16'd3, v); chk("R5 same gran keeps bank", 32'(v), 2);
    reg_wr(16'd2, 16'h0011);
    reg_rd(16'd3, v); chk("R5 gran change bank zero", 32'(v), 0);
    chk("R5 gran change plane zero", 32'(plane_off), 0);
    reg_rd(16'd2, v); chk("R5 ctrl readback", 32'(v), 32'h11);
    reg_wr(16'd3, 16'd7); chk("R6 bank 7 ok at 32K", 32'(bank_err), 0);
    acc("R2 32K bank7", 0, 32'h000A_0004, 1, 32'h0003_8004);
    reg_wr(16'd2, 16'h0001);
    reg_rd(16'd3, v); chk("R5 back to 64K bank zero", 32'(v), 0);

    // hole and linear region R1 R3 R4
    for (int i = 0; i < 4; i++) begin
      logic [31:0] ha;
      ha = 32'h000B_0000 + 32'(i) * 32'h0001_5555;
      acc("R3 hole read", 0, ha, 0, 0);
      acc("R3 hole write", 1, ha, 0, 0);
    end
    for (int i = 0; i < 8; i++) begin
      logic [31:0] o;
      o = 32'(i) * 32'h0000_7FFF;
      acc("R1 linear read", 0, BASE + o, 1, o);
      acc("R1 linear write", 1, BASE + o, 1, o);
    end
    acc("R1 linear last", 0, BASE + 32'(MEMB - 1), 1, 32'(MEMB - 1));
    acc("R4 linear beyond read", 0, BASE + 32'(MEMB), 0, 0);
    acc("R4 linear beyond write", 1, BASE + 32'(MEMB) + 32'h100, 0, 0);
    reg_wr(16'd3, 16'd3);
    acc("R4 bank3 top in", 0, 32'h000A_FFFF, 1, 32'h0003_FFFF);

    // same-cycle bank write and access R2
    reg_wr(16'd3, 16'd1);
    @(negedge clk); reg_idx_we = 1; reg_wdata = 16'd3;
    @(negedge clk); reg_idx_we = 0;
    reg_dat_we = 1; reg_wdata = 16'd2;
    cpu_req = 1; cpu_we = 1; cpu_addr = 32'h000A_0010;
    #1; chk("R2 race uses old bank", 32'(mem_addr), 32'h0001_0010);
    @(negedge clk); reg_dat_we = 0; cpu_req = 0; cpu_we = 0;
    acc("R2 after race new bank", 0, 32'h000A_0010, 1, 32'h0002_0010);

    // same-cycle granularity change and access R5
    @(negedge clk); reg_idx_we = 1; reg_wdata = 16'd2;
    @(negedge clk); reg_idx_we = 0;
    reg_dat_we = 1; reg_wdata = 16'h0011;
    cpu_req = 1; cpu_we = 0; cpu_addr = 32'h000A_0020;
    #1; chk("R5 race uses old gran", 32'(mem_addr), 32'h0002_0020);
    @(negedge clk); reg_dat_we = 0; cpu_req = 0;
    acc("R5 after race bank zero", 0, 32'h000A_0020, 1, 32'h0000_0020);

    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule